// File: doc/BRIEF.md
# Single-Position Register Shifter

This block takes an n-bit operand and moves it by exactly one bit position in one of six ways: logical left or right, circular left or right, and arithmetic left or right. A 3-bit operation code picks the kind of move. The shift itself is combinational. The result, an overflow flag and a valid flag are captured in registers, so they appear one clock after the inputs are presented with the valid strobe.

It is used as the shift stage next to an arithmetic/logic path. The arithmetic left shift reports signed overflow, which happens when the two top bits of the operand differ. Every other operation clears the flag. Multi-position and barrel shifting are not provided.

Top module: `shift_unit`

## Requirements
- R1: While reset is asserted (active low) and on the first edge after it, res_q, ovf_q and vld_q are all 0.
- R2: Code 000 (logical left) gives {a[N-2:0],0}. Code 001 (logical right) gives {0,a[N-1:1]}.
- R3: Code 010 (circular left) gives {a[N-2:0],a[N-1]}. Code 011 (circular right) gives {a[0],a[N-1:1]}.
- R4: Code 100 (arithmetic left) gives {a[N-2:0],0}, with ovf_q = a[N-1] XOR a[N-2].
- R5: Code 101 (arithmetic right) gives {a[N-1],a[N-1:1]}, so the sign bit is kept and also copied one position down.
- R6: Codes 110 and 111 pass the operand through unchanged.
- R7: ovf_q is 0 for every code other than 100.
- R8: vld_q equals the vld_i value from the previous clock. res_q and ovf_q are updated on any clock where vld_i is 1, and hold their values while vld_i is 0.
- R9: With N=8 and operand 11001010, the six codes 000 to 101 give 10010100, 01100101, 10010101, 01100101, 10010100 and 11100101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operand and code are valid |
| op_i | input | 3 | Shift kind select |
| a_i | input | N | Operand |
| res_q | output | N | Registered shifted value |
| ovf_q | output | 1 | Registered arithmetic-left overflow |
| vld_q | output | 1 | Registered valid, one clock after vld_i |

## Verification
The only state is the output register. A wrong select decode or a wrong fill bit appears on res_q on the clock after the strobe, and only for the affected code, so each code is driven with random operands and with corner operands. A stuck or wrongly gated overflow appears on ovf_q in that same cycle. A capture enable that is wrong shows up as res_q changing while vld_i is low.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    OP_LSL  = 3'b000,
    OP_LSR  = 3'b001,
    OP_ROL  = 3'b010,
    OP_ROR  = 3'b011,
    OP_ASL  = 3'b100,
    OP_ASR  = 3'b101,
    OP_PS0  = 3'b110,
    OP_PS1  = 3'b111
  } shift_op_e;
endpackage

// File: rtl/shift_core.sv
module shift_core #(
  parameter int N = 8
) (
  input  logic [2:0]   op,
  input  logic [N-1:0] a,
  output logic [N-1:0] y,
  output logic         ovf
);
  import shift_pkg::*;

  function automatic logic [N-1:0] fn_left(input logic [N-1:0] v, input logic fill);
    return {v[N-2:0], fill};
  endfunction

  function automatic logic [N-1:0] fn_right(input logic [N-1:0] v, input logic fill);
    return {fill, v[N-1:1]};
  endfunction

  logic [N-1:0] left_val, right_val;
  logic         left_fill, right_fill;
  logic         is_left;

  always_comb begin
    left_fill  = 1'b0;
    right_fill = 1'b0;
    is_left    = 1'b0;
    case (shift_op_e'(op))
      OP_LSL: is_left = 1'b1;
      OP_ROL: begin is_left = 1'b1; left_fill = a[N-1]; end
      OP_ASL: is_left = 1'b1;
      OP_ROR: right_fill = a[0];
      OP_ASR: right_fill = a[N-1];
      default: ;
    endcase
  end

  assign left_val  = fn_left(a, left_fill);
  assign right_val = fn_right(a, right_fill);

  always_comb begin
    if (op[2] & op[1])  y = a;
    else if (is_left)   y = left_val;
    else                y = right_val;
  end

  assign ovf = (op == 3'b100) ? (a[N-1] ^ a[N-2]) : 1'b0;

  always_comb begin
    if (op[2] & op[1]) a_pass_r6: assert (y == a);
    if (op != 3'b100)  a_ovf_zero_r7: assert (!ovf);
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [2:0]   op_i,
  input  logic [N-1:0] a_i,
  output logic [N-1:0] res_q,
  output logic         ovf_q,
  output logic         vld_q
);
  logic [N-1:0] core_y;
  logic         core_ovf;
  logic         cap_en;

  shift_core #(.N(N)) u_core (
    .op  (op_i),
    .a   (a_i),
    .y   (core_y),
    .ovf (core_ovf)
  );

  assign cap_en = vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (cap_en) begin
        res_q <= core_y;
        ovf_q <= core_ovf;
      end
    end
  end

  p_vld_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_q);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(res_q) && $stable(ovf_q) && !vld_q));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i != 3'b100) |=> !ovf_q);
  p_asl_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i == 3'b100) |=> (ovf_q == ($past(a_i[N-1]) ^ $past(a_i[N-2]))));
  p_asr_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i == 3'b101) |=> (res_q[N-1] == res_q[N-2]));
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  localparam int N = 8;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, vld_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [N-1:0] a_i = '0;
  logic [N-1:0] res_q;
  logic ovf_q, vld_q;
  int total = 0, bad = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  shift_unit #(.N(N)) u_shift_unit (.*);

  function automatic logic [N-1:0] exp_res(input logic [2:0] op, input logic [N-1:0] a);
    logic [N-1:0] r;
    r = a;
    case (op)
      3'd0, 3'd4: r = a << 1;
      3'd1: r = a >> 1;
      3'd2: r = (a << 1) | (a >> (N-1));
      3'd3: r = (a >> 1) | (a << (N-1));
      3'd5: r = $unsigned($signed(a) >>> 1);
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic logic exp_ovf(input logic [2:0] op, input logic [N-1:0] a);
    return (op == 3'd4) && (a[N-1] != a[N-2]);
  endfunction

  task automatic chk(input string tag, input logic [N:0] act, input logic [N:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [N-1:0] a, input string tag);
    vld_i = 1'b1; op_i = op; a_i = a;
    @(posedge clk); #1;
    chk(tag, {ovf_q, res_q}, {exp_ovf(op, a), exp_res(op, a)});
    chk({tag, " R8 vld"}, {{N{1'b0}}, vld_q}, {{N{1'b0}}, 1'b1});
  endtask

  initial begin
    logic [N-1:0] held;
    logic [N-1:0] golden [6];
    void'($urandom(32'd1234));
    golden = '{8'b10010100, 8'b01100101, 8'b10010101, 8'b01100101, 8'b10010100, 8'b11100101};
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset", {ovf_q, res_q}, '0);
    chk("R1 reset vld", {{N{1'b0}}, vld_q}, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", {vld_q, res_q}, '0);
    for (int k = 0; k < 6; k++) begin
      apply(3'(k), 8'b11001010, "R9 directed");
      chk("R9 table", {1'b0, res_q}, {1'b0, golden[k]});
    end
    apply(3'd4, 8'b01000000, "R4 ovf 01");
    apply(3'd4, 8'b11000000, "R4 no ovf 11");
    apply(3'd5, 8'b10000001, "R5 neg");
    apply(3'd5, 8'b01111111, "R5 pos");
    apply(3'd2, 8'b10000000, "R3 wrap");
    apply(3'd3, 8'b00000001, "R3 wrap r");
    apply(3'd0, 8'hFF, "R2 left fill");
    apply(3'd1, 8'hFF, "R2 right fill");
    apply(3'd6, 8'hA5, "R6 pass");
    apply(3'd7, 8'h5A, "R6 pass");
    apply(3'd1, 8'h40, "R7 no ovf");
    for (int i = 0; i < 400; i++)
      apply(3'($urandom_range(7)), N'($urandom), "R2-R7 random");
    held = res_q;
    vld_i = 1'b0; op_i = 3'd4; a_i = 8'h40;
    @(posedge clk); #1;
    chk("R8 hold res", {ovf_q, res_q}, {exp_ovf(3'd7, 8'h00), held});
    chk("R8 vld low", {{N{1'b0}}, vld_q}, '0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule